// File: doc/BRIEF.md
# Acquisition Trigger Controller

This block sequences one sampling function through its capture phases. Software picks a mode. The block answers with a status code. Together these form one byte, with the status in the upper nibble and the mode in the lower nibble.

A selected clock-source tick drives an internal divider, and the divider produces sample strobes. Capture runs through four phases:

1. The block fills a pre-start window of a programmed length.
2. It waits for a start trigger, then samples freely.
3. After a stop trigger it takes a programmed number of post-stop samples.
4. It either halts, or waits for the sample FIFO to drain and re-arms.

The converter and the FIFO sit outside the block. They are represented by an init-done input and a FIFO-empty input. Events are latched in a write-one-to-clear status vector. The enabled bits of that vector are combined into one interrupt line.

Top module: `acq_trig_ctrl`

## Requirements
- R1: After `rst_n` is released with mode 4, `mode_status_o` reads 0x84. The sample counter, the interrupt status and `sample_o` are all zero.
- R2: The first time the mode leaves 4 (uninitialized), the status reads 9 (initializing) and `init_req_o` is high until `init_done_i` is seen; then the status reads 0. While the status is 8 or 9, no sample is taken. After that first initialization, mode 4 gives status 0, and leaving mode 4 again does not repeat initialization.
- R3: Mode 0, and any mode value other than 1, 2, 3 or 4, stops sampling, clears the sample counter and gives status 0 one cycle later.
- R4: Mode 1 (pause) freezes the status, the counters and the divider. Triggers are ignored and no strobe is produced.
- R5: While running, a strobe occurs on every (`div_i`+1)-th cycle in which `clk_tick_i` is high. Interrupt bit 7 is set by every running tick.
- R6: Mode 2 or 3 entered from status 0 gives status 1 (pre-start fill). The status stays 1 until the number of samples taken equals `pre_len_i`, capped at FIFO_DEPTH (default 511). It then moves to status 2 and sets interrupt bit 2. A start trigger during status 1 is ignored.
- R7: A start trigger in status 2 gives status 3 and sets bit 3. It also restarts the divider, so the first strobe comes `div_i`+1 ticks after the trigger edge.
- R8: A stop trigger in status 3 gives status 4 and sets bit 4. Exactly `post_len_i` further strobes follow, zero included, and then bit 5 is set.
- R9: In mode 2 the block ends in status 7 and stays there while the mode is 2 or 3. Bit 6 is set once, the first time `fifo_empty_i` is seen high.
- R10: In mode 3 the block ends in status 5 and takes no samples until `fifo_empty_i` is high. It then sets bit 6 and returns to status 1 with a fresh pre-start fill.
- R11: Writing a 1 to a bit of `int_clr_i` clears only that bit of `int_stat_o`. `irq_o` is high when any enabled status bit is set. Bit 1 always reads 0.
- R12: `sample_cnt_o` increments by one for every strobe on `sample_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| mode_i | input | 4 | Operating mode: 0 reset, 1 pause, 2 single shot, 3 re-arm, 4 uninitialized |
| init_done_i | input | 1 | Converter initialization finished |
| init_req_o | output | 1 | Converter initialization in progress |
| clk_tick_i | input | 1 | Selected clock-source tick |
| start_trig_i | input | 1 | Start trigger pulse |
| stop_trig_i | input | 1 | Stop trigger pulse |
| div_i | input | DIV_W | Divider value; one strobe every `div_i`+1 ticks |
| pre_len_i | input | CNT_W | Pre-start sample count |
| post_len_i | input | CNT_W | Post-stop sample count |
| fifo_empty_i | input | 1 | Sample FIFO is empty |
| sample_o | output | 1 | Sample strobe |
| sample_cnt_o | output | CNT_W | Samples taken since the last reset mode |
| mode_status_o | output | 8 | {status, mode} |
| int_en_i | input | 8 | Interrupt enables |
| int_clr_i | input | 8 | Write-one-to-clear pulses |
| int_stat_o | output | 8 | Latched events: 0 sample, 2 pre-start filled, 3 start, 4 stop, 5 post-stop filled, 6 done with FIFO empty, 7 pacer tick |
| irq_o | output | 1 | OR of enabled status bits |

## Verification
A state register stuck in the wrong phase shows up in the upper nibble of `mode_status_o` on the very next clock. A wrong phase also shows as strobes where none are allowed, such as in status 5, 7, 8 or 9. A miscounting pre-start or post-stop counter shows as a wrong number of `sample_o` pulses between two status changes. That error appears as soon as the phase ends. A divider that is misaligned on the start trigger shows as a strobe in the wrong cycle within `div_i`+1 ticks of the trigger. Event bits that are lost or cleared wrongly are visible at `int_stat_o` one cycle after the event or the clear.

// File: rtl/acq_trig_ctrl.sv
module acq_trig_ctrl #(
  parameter int CNT_W      = 16,
  parameter int DIV_W      = 16,
  parameter int FIFO_DEPTH = 511
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [3:0]       mode_i,
  input  logic             init_done_i,
  output logic             init_req_o,
  input  logic             clk_tick_i,
  input  logic             start_trig_i,
  input  logic             stop_trig_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic [CNT_W-1:0] pre_len_i,
  input  logic [CNT_W-1:0] post_len_i,
  input  logic             fifo_empty_i,
  output logic             sample_o,
  output logic [CNT_W-1:0] sample_cnt_o,
  output logic [7:0]       mode_status_o,
  input  logic [7:0]       int_en_i,
  input  logic [7:0]       int_clr_i,
  output logic [7:0]       int_stat_o,
  output logic             irq_o
);

  typedef enum logic [3:0] {
    ST_STOP   = 4'h0,
    ST_PRE    = 4'h1,
    ST_WAIT   = 4'h2,
    ST_RUN    = 4'h3,
    ST_POST   = 4'h4,
    ST_REARM  = 4'h5,
    ST_DONE   = 4'h7,
    ST_UNINIT = 4'h8,
    ST_INIT   = 4'h9
  } st_t;

  localparam logic [3:0] M_RESET  = 4'h0;
  localparam logic [3:0] M_PAUSE  = 4'h1;
  localparam logic [3:0] M_SINGLE = 4'h2;
  localparam logic [3:0] M_REARM  = 4'h3;
  localparam logic [3:0] M_UNINIT = 4'h4;
  localparam logic [CNT_W-1:0] PRE_MAX = CNT_W'(FIFO_DEPTH);

  st_t              st, st_nx;
  logic             inited, drained;
  logic [CNT_W-1:0] pre_cnt, post_cnt, smp_cnt;
  logic [DIV_W-1:0] div_cnt;
  logic [7:0]       ev, int_stat;
  logic             clr_all, restart, realign, set_init, set_drained;

  logic go, pause, live, run, div_hit, pre_full, post_full;
  logic [CNT_W-1:0] pre_lim;

  assign go        = (mode_i == M_SINGLE) || (mode_i == M_REARM);
  assign pause     = (mode_i == M_PAUSE);
  assign live      = (st == ST_PRE) || (st == ST_WAIT) || (st == ST_RUN) || (st == ST_POST);
  assign run       = go && live;
  assign div_hit   = run && clk_tick_i && (div_cnt >= div_i);
  assign pre_lim   = (pre_len_i > PRE_MAX) ? PRE_MAX : pre_len_i;
  assign pre_full  = (pre_cnt >= pre_lim);
  assign post_full = (post_cnt >= post_len_i);
  assign sample_o  = div_hit && !((st == ST_PRE) && pre_full) && !((st == ST_POST) && post_full);

  always_comb begin
    st_nx       = st;
    ev          = '0;
    ev[0]       = sample_o;
    ev[7]       = run && clk_tick_i;
    clr_all     = 1'b0;
    restart     = 1'b0;
    realign     = 1'b0;
    set_init    = 1'b0;
    set_drained = 1'b0;
    if (mode_i == M_UNINIT) begin
      st_nx   = inited ? ST_STOP : ST_UNINIT;
      clr_all = 1'b1;
    end else if (st == ST_UNINIT) begin
      st_nx = ST_INIT;
    end else if (st == ST_INIT) begin
      if (init_done_i) begin
        st_nx    = ST_STOP;
        set_init = 1'b1;
      end
    end else if (!go && !pause) begin
      st_nx   = ST_STOP;
      clr_all = 1'b1;
    end else if (go) begin
      case (st)
        ST_STOP: begin
          st_nx   = ST_PRE;
          restart = 1'b1;
        end
        ST_PRE: if (pre_full) begin
          st_nx = ST_WAIT;
          ev[2] = 1'b1;
        end
        ST_WAIT: if (start_trig_i) begin
          st_nx   = ST_RUN;
          ev[3]   = 1'b1;
          realign = 1'b1;
        end
        ST_RUN: if (stop_trig_i) begin
          st_nx = ST_POST;
          ev[4] = 1'b1;
        end
        ST_POST: if (post_full) begin
          st_nx = (mode_i == M_REARM) ? ST_REARM : ST_DONE;
          ev[5] = 1'b1;
        end
        ST_REARM: if (fifo_empty_i) begin
          st_nx   = ST_PRE;
          ev[6]   = 1'b1;
          restart = 1'b1;
        end
        ST_DONE: if (fifo_empty_i && !drained) begin
          ev[6]       = 1'b1;
          set_drained = 1'b1;
        end
        default: st_nx = ST_STOP;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_UNINIT;
      inited   <= 1'b0;
      drained  <= 1'b0;
      pre_cnt  <= '0;
      post_cnt <= '0;
      smp_cnt  <= '0;
      div_cnt  <= '0;
      int_stat <= '0;
    end else begin
      st       <= st_nx;
      int_stat <= (int_stat & ~int_clr_i) | ev;
      if (set_init) inited <= 1'b1;
      if (clr_all) begin
        pre_cnt  <= '0;
        post_cnt <= '0;
        smp_cnt  <= '0;
        div_cnt  <= '0;
        drained  <= 1'b0;
      end else begin
        if (restart) begin
          pre_cnt  <= '0;
          post_cnt <= '0;
          drained  <= 1'b0;
        end else begin
          if (sample_o && st == ST_PRE)  pre_cnt  <= pre_cnt + 1'b1;
          if (sample_o && st == ST_POST) post_cnt <= post_cnt + 1'b1;
          if (set_drained) drained <= 1'b1;
        end
        if (restart || realign)     div_cnt <= '0;
        else if (run && clk_tick_i) div_cnt <= div_hit ? '0 : div_cnt + 1'b1;
        if (sample_o) smp_cnt <= smp_cnt + 1'b1;
      end
    end
  end

  assign init_req_o    = (st == ST_INIT);
  assign sample_cnt_o  = smp_cnt;
  assign mode_status_o = {st, mode_i};
  assign int_stat_o    = {int_stat[7:2], 1'b0, int_stat[0]};
  assign irq_o         = |(int_stat_o & int_en_i);

  AST_NO_SAMPLE_UNINIT: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_status_o[7:4] == 4'h8 || mode_status_o[7:4] == 4'h9) |-> !sample_o); // R2
  AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == M_RESET && st != ST_UNINIT && st != ST_INIT) |=> (sample_cnt_o == '0 && mode_status_o[7:4] == 4'h0)); // R3
  AST_PAUSE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (pause && st != ST_UNINIT && st != ST_INIT) |=> ($stable(sample_cnt_o) && $stable(st))); // R4
  AST_DONE_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_DONE && go) |=> st == ST_DONE); // R9
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    sample_o |=> sample_cnt_o == CNT_W'($past(sample_cnt_o) + 1'b1)); // R12

endmodule

// File: tb/acq_trig_ctrl_test.sv
module acq_trig_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  mode = 4'h4;
  logic        init_done = 1'b0, start = 1'b0, stop = 1'b0, fifo_empty = 1'b0;
  logic        gap = 1'b0, tg = 1'b0;
  logic [15:0] div = '0, pre = '0, post = '0;
  logic [7:0]  int_en = '0, int_clr = '0;
  logic        init_req, sample, irq, clk_tick;
  logic [15:0] scnt;
  logic [7:0]  mstat, istat;
  int checks = 0, errors = 0, nsamp = 0, base = 0;
  bit  done = 0;

  always #5 clk = ~clk;
  always @(negedge clk) tg <= ~tg;
  assign clk_tick = gap ? tg : 1'b1;
  always @(posedge clk) if (sample) nsamp++;

  acq_trig_ctrl uut (
    .clk(clk), .rst_n(rst_n), .mode_i(mode), .init_done_i(init_done), .init_req_o(init_req),
    .clk_tick_i(clk_tick), .start_trig_i(start), .stop_trig_i(stop), .div_i(div),
    .pre_len_i(pre), .post_len_i(post), .fifo_empty_i(fifo_empty), .sample_o(sample),
    .sample_cnt_o(scnt), .mode_status_o(mstat), .int_en_i(int_en), .int_clr_i(int_clr),
    .int_stat_o(istat), .irq_o(irq)
  );

  task automatic chk(input string r, input longint act, input longint exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", r, act, exp);
    end
  endtask

  task automatic nxt(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_st(input logic [3:0] s, input int lim, input string r);
    int k = 0;
    while (mstat[7:4] !== s && k < lim) begin
      nxt();
      k++;
    end
    chk(r, mstat[7:4], s);
  endtask

  task automatic clear_ints();
    int_clr = 8'hff; nxt(); int_clr = 8'h00;
  endtask

  task automatic go_reset();
    mode = 4'h0; nxt(); base = nsamp;
  endtask

  task automatic t_reset();
    chk("R1 mode_status", mstat, 8'h84);
    chk("R1 sample_cnt", scnt, 0);
    chk("R1 int_stat", istat, 0);
    chk("R1 sample", sample, 0);
  endtask

  task automatic t_init();
    mode = 4'h0; nxt();
    chk("R2 initializing", mstat, 8'h90);
    chk("R2 init_req", init_req, 1);
    nxt(3);
    chk("R2 still initializing", mstat, 8'h90);
    chk("R2 no sample", sample, 0);
    init_done = 1'b1; nxt(); init_done = 1'b0;
    chk("R2 stopped after init", mstat, 8'h00);
    chk("R2 init_req low", init_req, 0);
    mode = 4'h4; nxt();
    chk("R2 uninit mode after init", mstat, 8'h04);
    go_reset();
    chk("R2 no second init", mstat, 8'h00);
  endtask

  task automatic t_single();
    int n0, sc;
    div = 16'd3; pre = 16'd3; post = 16'd2; fifo_empty = 1'b0;
    clear_ints();
    mode = 4'h2; nxt();
    chk("R6 prestart fill", mstat[7:4], 4'h1);
    n0 = nsamp;
    nxt(2);
    start = 1'b1; nxt(); start = 1'b0;
    chk("R6 start ignored in fill", mstat[7:4], 4'h1);
    wait_st(4'h2, 100, "R6 reach wait");
    chk("R6 prestart count", nsamp - n0, 3);
    chk("R6 bit2", istat[2], 1);
    chk("R7 bit3 not yet", istat[3], 0);
    nxt(2);
    start = 1'b1; nxt(); start = 1'b0;
    chk("R7 sampling", mstat[7:4], 4'h3);
    chk("R7 bit3", istat[3], 1);
    for (int k = 0; k < 4; k++) begin
      chk("R7 divider realign", sample, (k == 3) ? 1 : 0);
      nxt();
    end
    chk("R5 pacer bit7", istat[7], 1);
    chk("R12 sample bit0", istat[0], 1);
    gap = 1'b1;
    begin
      int k = 0, d = 0;
      while (!sample && k < 40) begin nxt(); k++; end
      nxt(); d = 1;
      while (!sample && d < 40) begin nxt(); d++; end
      chk("R5 strobe interval", d, 8);
    end
    gap = 1'b0;
    sc = scnt;
    mode = 4'h1; nxt(4);
    chk("R4 pause status", mstat, 8'h31);
    chk("R4 pause count", scnt, sc);
    chk("R4 pause no strobe", sample, 0);
    stop = 1'b1; nxt(); stop = 1'b0;
    chk("R4 stop ignored", mstat[7:4], 4'h3);
    mode = 4'h2; nxt();
    stop = 1'b1; nxt(); stop = 1'b0;
    chk("R8 post state", mstat[7:4], 4'h4);
    chk("R8 bit4", istat[4], 1);
    n0 = nsamp;
    wait_st(4'h7, 100, "R9 done");
    chk("R8 post count", nsamp - n0, 2);
    chk("R8 bit5", istat[5], 1);
    chk("R9 bit6 waits for fifo", istat[6], 0);
    nxt(3);
    chk("R9 stays done", mstat, 8'h72);
    chk("R12 counter", scnt, nsamp - base);
    fifo_empty = 1'b1; nxt();
    chk("R9 bit6", istat[6], 1);
    int_en = 8'h40;
    #1 chk("R11 irq enabled", irq, 1);
    int_en = 8'h02;
    #1 chk("R11 irq masked", irq, 0);
    int_clr = 8'h40; nxt(); int_clr = 8'h00;
    chk("R11 cleared bit", istat[6], 0);
    chk("R11 other bit kept", istat[5], 1);
    chk("R11 bit1 zero", istat[1], 0);
    nxt(3);
    chk("R9 bit6 once", istat[6], 0);
    start = 1'b1; nxt(); start = 1'b0;
    chk("R9 no restart", mstat[7:4], 4'h7);
    int_en = 8'h00;
  endtask

  task automatic t_unlisted();
    mode = 4'hA; nxt();
    chk("R3 unlisted mode", mstat, 8'h0A);
    chk("R3 counter cleared", scnt, 0);
    go_reset();
    chk("R3 reset mode", mstat, 8'h00);
  endtask

  task automatic t_rearm();
    int n0;
    div = 16'd0; pre = 16'd2; post = 16'd1; fifo_empty = 1'b0;
    clear_ints();
    mode = 4'h3; nxt();
    wait_st(4'h2, 50, "R10 first fill");
    start = 1'b1; nxt(); start = 1'b0;
    nxt(2);
    stop = 1'b1; nxt(); stop = 1'b0;
    wait_st(4'h5, 50, "R10 wait rearm");
    n0 = nsamp;
    nxt(4);
    chk("R10 holding", mstat[7:4], 4'h5);
    chk("R10 no samples", nsamp - n0, 0);
    fifo_empty = 1'b1; nxt(); fifo_empty = 1'b0;
    chk("R10 refill", mstat[7:4], 4'h1);
    chk("R10 bit6", istat[6], 1);
    n0 = nsamp;
    wait_st(4'h2, 50, "R10 second fill");
    chk("R10 refill count", nsamp - n0, 2);
  endtask

  task automatic t_edges();
    int n0;
    go_reset();
    pre = 16'd600; div = 16'd0;
    mode = 4'h2; nxt();
    n0 = nsamp;
    wait_st(4'h2, 2000, "R6 clamp reach");
    chk("R6 clamp to fifo depth", nsamp - n0, 511);
    go_reset();
    clear_ints();
    pre = 16'd0; post = 16'd0;
    mode = 4'h2; nxt(); nxt();
    chk("R6 empty window", mstat[7:4], 4'h2);
    chk("R6 bit2 empty window", istat[2], 1);
    start = 1'b1; nxt(); start = 1'b0;
    stop = 1'b1; nxt(); stop = 1'b0;
    n0 = nsamp;
    nxt();
    chk("R8 zero post done", mstat[7:4], 4'h7);
    chk("R8 zero post count", nsamp - n0, 0);
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    nxt(3);
    rst_n = 1'b1;
    nxt();
    t_reset();
    t_init();
    t_single();
    t_unlisted();
    t_rearm();
    t_edges();
    summary();
  end

  initial begin
    #1_000_000;
    checks++;
    errors++;
    $display("FAIL watchdog: all requirements, actual timeout expected completion");
    summary();
  end
endmodule